// File: doc/BRIEF.md
# Button Event Report Decoder

This block sits behind a byte-wide serial slave front end and turns short command frames from a host controller into a live picture of a small button panel. The front end supplies each received byte together with a level that is high while the frame's chip select is asserted. The decoder counts bytes within the frame. It accepts only frames that open with the report command code. From those frames it takes a 16-bit absolute key state and a 16-bit mask marking the key that changed.

When the last byte of a valid frame arrives, the decoder loads the held-key register. In the same step it raises one-cycle pulses: a press pulse for each masked key that is now held, and a release pulse for each masked key that is now released. Frames with any other command code are ignored. Frames cut short by chip-select release are ignored. Bytes past the end of a frame are ignored.

Top module: `keyrpt_decoder`

## Requirements
- R1: After reset, key_state, key_press and key_release are all zero.
- R2: A report frame is five bytes whose first byte is 8'hF4; bytes two and three carry the key state with the high byte first. On the clock edge that accepts the fifth byte, key_state takes that value, and it holds until the next accepted report.
- R3: Bytes four and five carry the change mask with the high byte first. Each mask bit whose new state bit is 1 produces a key_press bit for exactly the one cycle after the fifth byte's edge.
- R4: Each mask bit whose new state bit is 0 produces a key_release bit for that same single cycle. A bit never pulses press and release together.
- R5: A frame whose first byte is not 8'hF4 changes neither key_state nor the pulse outputs.
- R6: Dropping sel_active before the fifth byte discards the frame. The next frame is decoded from its first byte as the command code.
- R7: Bytes after the fifth within one chip-select period are ignored.
- R8: Bit positions at and above NUM_KEYS (11 by default; bit 0 down, 1 up, 2 left, 3 right, 4 stick press, 5 home, 6 menu, 7 select, 8 start, 9 accept, 10 back) never appear set in key_state, key_press or key_release.
- R9: key_state follows the absolute state field for every key, including keys absent from the mask.
- R10: Cycles with byte_valid low between bytes have no effect on the byte count or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| sel_active | input | 1 | High while the frame's chip select is asserted |
| byte_valid | input | 1 | byte_data holds a received byte this cycle |
| byte_data | input | 8 | Received byte |
| key_state | output | 16 | Held-key register |
| key_press | output | 16 | One-cycle press events |
| key_release | output | 16 | One-cycle release events |

## Verification
Every result in this block is due one cycle after the rising edge that accepts a frame's fifth byte. key_state changes there and stays. Each press or release pulse is high for that cycle only and is zero on all other cycles. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge. It compares all three outputs with the model at every following falling edge, so a result that arrives a cycle early, arrives a cycle late or lasts too long is a mismatch.

// File: rtl/keyrpt_pkg.sv
package keyrpt_pkg;
  localparam int            BYTE_W      = 8;
  localparam int            WORD_W      = 16;
  localparam int            FRAME_BYTES = 5;
  localparam logic [7:0]    REPORT_CODE = 8'hF4;
  typedef logic [2:0]       byte_idx_t;
  localparam byte_idx_t     IDX_LAST    = byte_idx_t'(FRAME_BYTES - 1);
  localparam byte_idx_t     IDX_DONE    = byte_idx_t'(FRAME_BYTES);
endpackage

// File: rtl/keyrpt_byte_seq.sv
module keyrpt_byte_seq
  import keyrpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output byte_idx_t         byte_idx,
  output logic              take,
  output logic              commit
);
  byte_idx_t idx_q, idx_d;
  logic      code_ok_q, code_ok_d;

  assign take   = sel_active && byte_valid && (idx_q < IDX_DONE);
  assign commit = take && (idx_q == IDX_LAST) && code_ok_q;
  assign byte_idx = idx_q;

  always_comb begin
    idx_d     = idx_q;
    code_ok_d = code_ok_q;
    if (!sel_active) begin
      idx_d     = '0;
      code_ok_d = 1'b0;
    end else if (take) begin
      idx_d = idx_q + byte_idx_t'(1);
      if (idx_q == '0) code_ok_d = (byte_data == REPORT_CODE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      code_ok_q <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      code_ok_q <= code_ok_d;
    end
  end

  // Deselect restarts the frame at the command byte
  assert_restart_on_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> (idx_q == '0));
  // Count saturates after the last frame byte
  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_DONE);
  // Idle cycles leave the count alone
  assert_idle_holds_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && !byte_valid) |=> $stable(idx_q));
endmodule

// File: rtl/keyrpt_assemble.sv
module keyrpt_assemble
  import keyrpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  byte_idx_t         byte_idx,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [WORD_W-1:0] state_word,
  output logic [WORD_W-1:0] mask_word
);
  localparam int HELD = FRAME_BYTES - 2;
  logic [HELD*BYTE_W-1:0] held_w;

  for (genvar g = 1; g <= HELD; g++) begin : g_field
    logic [BYTE_W-1:0] fq, fd;
    logic              en;
    assign en = take && (byte_idx == byte_idx_t'(g));
    always_comb begin
      fd = fq;
      if (en) fd = byte_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fq <= '0;
      else        fq <= fd;
    end
    assign held_w[(g-1)*BYTE_W +: BYTE_W] = fq;
  end

  // High byte travels first on the wire
  assign state_word = {held_w[0 +: BYTE_W], held_w[BYTE_W +: BYTE_W]};
  assign mask_word  = {held_w[2*BYTE_W +: BYTE_W], byte_data};
endmodule

// File: rtl/keyrpt_event_gen.sv
module keyrpt_event_gen
  import keyrpt_pkg::*;
#(
  parameter int NUM_KEYS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] new_state,
  input  logic [WORD_W-1:0] new_mask,
  output logic [WORD_W-1:0] key_state,
  output logic [WORD_W-1:0] key_press,
  output logic [WORD_W-1:0] key_release
);
  localparam logic [WORD_W-1:0] USED =
    (NUM_KEYS >= WORD_W) ? {WORD_W{1'b1}} : WORD_W'((32'd1 << NUM_KEYS) - 32'd1);

  logic [WORD_W-1:0] st_q, st_d, pr_q, pr_d, rl_q, rl_d;
  logic [WORD_W-1:0] st_in, mk_in;

  assign st_in = new_state & USED;
  assign mk_in = new_mask & USED;

  always_comb begin
    st_d = st_q;
    pr_d = '0;
    rl_d = '0;
    if (commit) begin
      st_d = st_in;
      pr_d = mk_in & st_in;
      rl_d = mk_in & ~st_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      pr_q <= '0;
      rl_q <= '0;
    end else begin
      st_q <= st_d;
      pr_q <= pr_d;
      rl_q <= rl_d;
    end
  end

  assign key_state   = st_q;
  assign key_press   = pr_q;
  assign key_release = rl_q;

  assert_state_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(key_state));
  assert_press_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (key_press == '0));
  assert_press_is_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_press & ~key_state) == '0);
  assert_release_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (key_release == '0));
  assert_release_not_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_release & key_state) == '0);
  assert_unused_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_state | key_press | key_release) & ~USED) == '0);
endmodule

// File: rtl/keyrpt_decoder.sv
module keyrpt_decoder
  import keyrpt_pkg::*;
#(
  parameter int NUM_KEYS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_active,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic [15:0] key_state,
  output logic [15:0] key_press,
  output logic [15:0] key_release
);
  logic      rst_meta, rst_sync;
  byte_idx_t byte_idx;
  logic      take, commit;
  logic [WORD_W-1:0] state_word, mask_word;

  // Asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  keyrpt_byte_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .sel_active (sel_active),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_idx   (byte_idx),
    .take       (take),
    .commit     (commit)
  );

  keyrpt_assemble u_asm (
    .clk        (clk),
    .rst_n      (rst_sync),
    .take       (take),
    .byte_idx   (byte_idx),
    .byte_data  (byte_data),
    .state_word (state_word),
    .mask_word  (mask_word)
  );

  keyrpt_event_gen #(.NUM_KEYS(NUM_KEYS)) u_evt (
    .clk         (clk),
    .rst_n       (rst_sync),
    .commit      (commit),
    .new_state   (state_word),
    .new_mask    (mask_word),
    .key_state   (key_state),
    .key_press   (key_press),
    .key_release (key_release)
  );

  assert_no_commit_without_select_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    !sel_active |=> (key_press == '0 && key_release == '0));
endmodule

// File: tb/keyrpt_decoder_tb.sv
module keyrpt_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_active = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [15:0] key_state, key_press, key_release;

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  keyrpt_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sel_active(sel_active), .byte_valid(byte_valid),
    .byte_data(byte_data), .key_state(key_state), .key_press(key_press),
    .key_release(key_release)
  );

  // Behavioural reference model
  logic [7:0]  bq[$];
  logic [15:0] m_state = 0, m_press = 0, m_rel = 0;
  localparam logic [15:0] USED_BITS = 16'h07FF; // R8: keys 0..10

  always @(posedge clk) begin
    m_press = 0;
    m_rel   = 0;
    if (!rst_n) begin
      m_state = 0;
      bq.delete();
    end else if (!sel_active) begin
      bq.delete();
    end else if (byte_valid && bq.size() < 5) begin
      bq.push_back(byte_data);
      if (bq.size() == 5 && bq[0] == 8'hF4) begin
        logic [15:0] s, m;
        s = {bq[1], bq[2]} & USED_BITS;
        m = {bq[3], bq[4]} & USED_BITS;
        m_state = s;
        m_press = m & s;
        m_rel   = m & ~s;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (key_state !== m_state || key_press !== m_press || key_release !== m_rel) begin
        n_fail++;
        $display("FAIL %s: state=%h press=%h release=%h expected state=%h press=%h release=%h",
                 cur_req, key_state, key_press, key_release, m_state, m_press, m_rel);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(logic [7:0] d, int gap);
    @(negedge clk);
    sel_active = 1'b1; byte_valid = 1'b1; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0; byte_data = $urandom;
    repeat (gap) @(negedge clk);
  endtask

  task automatic end_frame();
    @(negedge clk);
    sel_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic report(logic [7:0] code, logic [15:0] st, logic [15:0] mk, int gap);
    put_byte(code, gap); put_byte(st[15:8], gap); put_byte(st[7:0], gap);
    put_byte(mk[15:8], gap); put_byte(mk[7:0], gap);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    n_tests++;
    if (key_state !== 0 || key_press !== 0 || key_release !== 0) begin
      n_fail++;
      $display("FAIL R1: state=%h press=%h release=%h expected all 0", key_state, key_press, key_release);
    end
    cur_req = "R2/R3 press";      report(8'hF4, 16'h0001, 16'h0001, 0); end_frame();
    cur_req = "R4 release";       report(8'hF4, 16'h0000, 16'h0001, 0); end_frame();
    cur_req = "R9 absolute";      report(8'hF4, 16'h0206, 16'h0004, 0); end_frame();
    cur_req = "R3 high byte";     report(8'hF4, 16'h0606, 16'h0400, 1); end_frame();
    cur_req = "R8 unused bits";   report(8'hF4, 16'hFFFF, 16'hFFFF, 0); end_frame();
    cur_req = "R8 unused release"; report(8'hF4, 16'hF800, 16'hFFFF, 0); end_frame();
    cur_req = "R5 other code";    report(8'hF3, 16'h0155, 16'h0155, 0); end_frame();
    cur_req = "R5 zero code";     report(8'h00, 16'h03FF, 16'h0001, 0); end_frame();
    cur_req = "R6 short frame";
    put_byte(8'hF4, 0); put_byte(8'h01, 0); put_byte(8'h23, 0); put_byte(8'h00, 0);
    end_frame();
    cur_req = "R6 restart";
    put_byte(8'h00, 0); end_frame();
    report(8'hF4, 16'h0123, 16'h0120, 0); end_frame();
    cur_req = "R7 extra bytes";
    report(8'hF4, 16'h0010, 16'h0010, 0);
    put_byte(8'hF4, 0); put_byte(8'h00, 0); put_byte(8'h00, 0); put_byte(8'hFF, 0); put_byte(8'hFF, 0);
    end_frame();
    cur_req = "R10 gaps";         report(8'hF4, 16'h0480, 16'h0480, 3); end_frame();
    cur_req = "R2 back to back";
    report(8'hF4, 16'h0001, 16'h0001, 0); sel_active = 1'b0; @(negedge clk);
    report(8'hF4, 16'h0003, 16'h0002, 0); end_frame();
    cur_req = "R2-mix random";
    for (int i = 0; i < 300; i++) begin
      int len = 3 + ($urandom % 5);
      for (int b = 0; b < len; b++) begin
        logic [7:0] d;
        d = $urandom;
        if (b == 0 && ($urandom % 10) < 8) d = 8'hF4;
        put_byte(d, $urandom % 3);
      end
      end_frame();
    end
    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule